// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Unit

This block holds the hazard control for a five-stage in-order RV32 integer pipeline. The stages are fetch, decode, execute, memory and writeback. The block watches the source register indices of the instructions in decode and execute. It also watches the destination index, the write enable and the load flag of the instructions further down the pipe. From these it raises stall and flush strobes and picks, for each execute operand, where the operand value comes from.

The stage records are carried in a thin harness of pipeline registers, so that bubble insertion and forwarding can be observed at the ports together. The ALU result, the register-file read data and the loaded word arrive as inputs. The forwarded operand values leave as outputs. The first forwarded operand is the base of the jump/branch target adder. The second becomes the store data of the memory stage. Branches resolve in the memory stage. A load followed at once by a dependent instruction costs one stall cycle, because writeback results are forwarded into execute.

Top module: `pipe_hazard_unit`

## Requirements
- R1: When `memBranchTaken` is high, `flushDecode` and `flushExec` are both high in that same cycle. The instructions then in decode and execute never reach writeback: `wbWe` is low in the cycles they would have occupied there.
- R2: If the instruction in decode reads a nonzero register that the load in execute writes, then `stallDecode` and `stallFetch` are high for that cycle. The held instruction then enters execute one cycle late, and a bubble enters execute meanwhile.
- R3: A load-use dependence costs exactly one stall cycle. In the following cycle no stall is raised. When the consumer reaches execute, it receives the loaded word through the writeback path.
- R4: An execute operand whose nonzero source matches the destination of a writing instruction in the memory stage selects code 1 (memory stage). Its value is the ALU result registered for that instruction. `exOpA` carries the forwarded first operand.
- R5: Otherwise, a match against a writing instruction in writeback selects code 2, with the writeback value. With no match, the operand selects code 0 and takes the register-file data.
- R6: When both the memory and the writeback stage match a source, the memory stage (the younger result) wins.
- R7: Register x0 never causes a stall and is never forwarded (select code 0). An operand reading x0 is zero whatever the register-file data is.
- R8: Bubbles created by a flush or a stall never write back and never act as a forwarding source.
- R9: When a flush and a stall fall on the same cycle, the flush wins. Both stall strobes stay low, and the fetched instruction is accepted.
- R10: `memStoreData` equals the forwarded second operand (`exOpB`) of the cycle before.
- R11: While reset is held, all stall and flush strobes are low, `wbWe` is low and `memStoreData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inRs1 | input | 5 | First source index of the fetched instruction |
| inRs2 | input | 5 | Second source index of the fetched instruction |
| inRd | input | 5 | Destination index of the fetched instruction |
| inWe | input | 1 | Fetched instruction writes its destination |
| inLoad | input | 1 | Fetched instruction is a load |
| memBranchTaken | input | 1 | Branch in memory stage is taken |
| rfDataA | input | 32 | Register-file data for execute operand A |
| rfDataB | input | 32 | Register-file data for execute operand B |
| exResult | input | 32 | ALU result of the instruction in execute |
| memLoadData | input | 32 | Loaded word for the instruction in the memory stage |
| stallFetch | output | 1 | Hold the fetch stage |
| stallDecode | output | 1 | Hold the decode stage |
| flushDecode | output | 1 | Squash the instruction in decode |
| flushExec | output | 1 | Squash the instruction in execute |
| fwdSelA | output | 2 | Source of operand A: 0 register file, 1 memory, 2 writeback |
| fwdSelB | output | 2 | Source of operand B, same coding |
| exOpA | output | 32 | Forwarded operand A (branch target base) |
| exOpB | output | 32 | Forwarded operand B |
| memStoreData | output | 32 | Store data held in the memory stage |
| wbWe | output | 1 | Writeback stage writes its destination |
| wbRd | output | 5 | Writeback destination index |
| wbValue | output | 32 | Writeback value |

## Verification
Stall and flush strobes depend on the current stage contents only, so they are checked in the very cycle the condition holds. An instruction presented at the fetch inputs sits in decode one edge later and in execute two edges later. Its operand select and forwarded value are therefore checked in that execute cycle. Its store data is checked one cycle after that, and its writeback fields four cycles after issue. The bench applies each cycle's inputs after the falling edge, waits one time unit, and samples there. Every data input carries the current cycle number, so each expected value names the exact cycle its source was produced in.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Operand source codes seen by the execute-stage muxes
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_MEMSTG  = 2'd1,
    SRC_WBSTG   = 2'd2
  } fwdSrc_e;

  // Strobes from hazard control to the stage registers and muxes
  typedef struct packed {
    logic             stallFetch;
    logic             stallDecode;
    logic             flushDecode;
    logic             flushExec;
    fwdSrc_e [1:0]    opSrc;
  } hzdStrobes_t;

endpackage

// File: rtl/hzd_control.sv
module hzd_control
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            memBranchTaken,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   dRs,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   eRs,
  input  logic [IDX_W-1:0]                eRd,
  input  logic                            eWe,
  input  logic                            eLoad,
  input  logic [IDX_W-1:0]                mRd,
  input  logic                            mWe,
  input  logic [IDX_W-1:0]                wRd,
  input  logic                            wWe,
  output hzdStrobes_t                     strobes
);

  logic [NUM_SRC-1:0] decHit;
  fwdSrc_e [1:0]      opSrc;
  logic               loadUse;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      // decode reader waits on a load that has not produced data yet
      assign decHit[g] = (dRs[g] == eRd);
      // younger memory-stage result first, then writeback
      assign opSrc[g] = (eRs[g] == '0)                ? SRC_REGFILE :
                        (mWe && (mRd == eRs[g]))      ? SRC_MEMSTG  :
                        (wWe && (wRd == eRs[g]))      ? SRC_WBSTG   :
                                                        SRC_REGFILE;
    end
  endgenerate

  assign loadUse = eWe && eLoad && (eRd != '0) && (|decHit);

  always_comb begin
    strobes.flushDecode = memBranchTaken;
    strobes.flushExec   = memBranchTaken;
    strobes.stallDecode = loadUse && !memBranchTaken;
    strobes.stallFetch  = loadUse && !memBranchTaken;
    strobes.opSrc       = opSrc;
  end

endmodule

// File: rtl/hzd_datapath.sv
module hzd_datapath
  import hzd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDX_W = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  hzdStrobes_t                     strobes,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   inRs,
  input  logic [IDX_W-1:0]                inRd,
  input  logic                            inWe,
  input  logic                            inLoad,
  input  logic [NUM_SRC-1:0][XLEN-1:0]    rfData,
  input  logic [XLEN-1:0]                 exResult,
  input  logic [XLEN-1:0]                 memLoadData,
  output logic [NUM_SRC-1:0][IDX_W-1:0]   dRs,
  output logic [NUM_SRC-1:0][IDX_W-1:0]   eRs,
  output logic [IDX_W-1:0]                eRd,
  output logic                            eWe,
  output logic                            eLoad,
  output logic [IDX_W-1:0]                mRd,
  output logic                            mWe,
  output logic [IDX_W-1:0]                wRd,
  output logic                            wWe,
  output logic [NUM_SRC-1:0][XLEN-1:0]    exOp,
  output logic [XLEN-1:0]                 memStoreData,
  output logic [XLEN-1:0]                 wbValue
);

  localparam int STORE_SRC = NUM_SRC - 1;

  logic [IDX_W-1:0] dRd;
  logic             dWe;
  logic             dLoad;
  logic             mLoad;
  logic [XLEN-1:0]  mResult;
  logic             killExecEntry;

  // decode stage record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dRs   <= '0;
      dRd   <= '0;
      dWe   <= 1'b0;
      dLoad <= 1'b0;
    end else if (!strobes.stallDecode) begin
      dRs   <= inRs;
      dRd   <= inRd;
      dWe   <= inWe;
      dLoad <= inLoad;
    end
  end

  // execute stage record: squashed decode or a stall both leave a bubble
  assign killExecEntry = strobes.flushDecode || strobes.stallDecode;

  always_ff @(posedge clk) begin
    if (!rstN || killExecEntry) begin
      eRs   <= '0;
      eRd   <= '0;
      eWe   <= 1'b0;
      eLoad <= 1'b0;
    end else begin
      eRs   <= dRs;
      eRd   <= dRd;
      eWe   <= dWe;
      eLoad <= dLoad;
    end
  end

  // memory stage record
  always_ff @(posedge clk) begin
    if (!rstN || strobes.flushExec) begin
      mRd   <= '0;
      mWe   <= 1'b0;
      mLoad <= 1'b0;
    end else begin
      mRd   <= eRd;
      mWe   <= eWe;
      mLoad <= eLoad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mResult      <= '0;
      memStoreData <= '0;
    end else begin
      mResult      <= exResult;
      memStoreData <= exOp[STORE_SRC];
    end
  end

  // writeback record: the load/result choice is made before this register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wRd     <= '0;
      wWe     <= 1'b0;
      wbValue <= '0;
    end else begin
      wRd     <= mRd;
      wWe     <= mWe;
      wbValue <= mLoad ? memLoadData : mResult;
    end
  end

  // execute operand muxes
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_opmux
      assign exOp[g] = (eRs[g] == '0)                     ? '0      :
                       (strobes.opSrc[g] == SRC_MEMSTG)   ? mResult :
                       (strobes.opSrc[g] == SRC_WBSTG)    ? wbValue :
                                                            rfData[g];
    end
  endgenerate

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hzd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] inRs1,
  input  logic [IDX_W-1:0] inRs2,
  input  logic [IDX_W-1:0] inRd,
  input  logic             inWe,
  input  logic             inLoad,
  input  logic             memBranchTaken,
  input  logic [XLEN-1:0]  rfDataA,
  input  logic [XLEN-1:0]  rfDataB,
  input  logic [XLEN-1:0]  exResult,
  input  logic [XLEN-1:0]  memLoadData,
  output logic             stallFetch,
  output logic             stallDecode,
  output logic             flushDecode,
  output logic             flushExec,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic [XLEN-1:0]  exOpA,
  output logic [XLEN-1:0]  exOpB,
  output logic [XLEN-1:0]  memStoreData,
  output logic             wbWe,
  output logic [IDX_W-1:0] wbRd,
  output logic [XLEN-1:0]  wbValue
);

  localparam int NUM_SRC = 2;

  hzdStrobes_t                    strobes;
  logic [NUM_SRC-1:0][IDX_W-1:0]  dRs;
  logic [NUM_SRC-1:0][IDX_W-1:0]  eRs;
  logic [IDX_W-1:0]               eRd;
  logic                           eWe;
  logic                           eLoad;
  logic [IDX_W-1:0]               mRd;
  logic                           mWe;
  logic [NUM_SRC-1:0][XLEN-1:0]   exOp;

  hzd_control #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_control (
    .memBranchTaken (memBranchTaken),
    .dRs            (dRs),
    .eRs            (eRs),
    .eRd            (eRd),
    .eWe            (eWe),
    .eLoad          (eLoad),
    .mRd            (mRd),
    .mWe            (mWe),
    .wRd            (wbRd),
    .wWe            (wbWe),
    .strobes        (strobes)
  );

  hzd_datapath #(.XLEN(XLEN), .IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .inRs         ({inRs2, inRs1}),
    .inRd         (inRd),
    .inWe         (inWe),
    .inLoad       (inLoad),
    .rfData       ({rfDataB, rfDataA}),
    .exResult     (exResult),
    .memLoadData  (memLoadData),
    .dRs          (dRs),
    .eRs          (eRs),
    .eRd          (eRd),
    .eWe          (eWe),
    .eLoad        (eLoad),
    .mRd          (mRd),
    .mWe          (mWe),
    .wRd          (wbRd),
    .wWe          (wbWe),
    .exOp         (exOp),
    .memStoreData (memStoreData),
    .wbValue      (wbValue)
  );

  assign stallFetch  = strobes.stallFetch;
  assign stallDecode = strobes.stallDecode;
  assign flushDecode = strobes.flushDecode;
  assign flushExec   = strobes.flushExec;
  assign fwdSelA     = strobes.opSrc[0];
  assign fwdSelB     = strobes.opSrc[1];
  assign exOpA       = exOp[0];
  assign exOpB       = exOp[1];

endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            memBranchTaken,
  input logic            stallFetch,
  input logic            stallDecode,
  input logic            flushDecode,
  input logic            flushExec,
  input logic [XLEN-1:0] exOpB,
  input logic [XLEN-1:0] memStoreData,
  input logic            wbWe
);

  // R1: a taken branch squashes both younger stages in the same cycle
  p_flush_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    memBranchTaken |-> (flushDecode && flushExec));

  // R2: fetch and decode are held together
  p_stall_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    stallDecode |-> stallFetch);

  // R3: never two stall cycles in a row
  p_single_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    stallDecode |=> !stallDecode);

  // R9: flush overrides any stall
  p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushDecode |-> (!stallDecode && !stallFetch));

  // R10: store data is last cycle's forwarded second operand
  p_store_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (memStoreData == $past(exOpB)));

  // R8: the squashed execute instruction never writes back
  p_bubble_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(flushExec, 2) |-> !wbWe);

endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .memBranchTaken (memBranchTaken),
  .stallFetch     (stallFetch),
  .stallDecode    (stallDecode),
  .flushDecode    (flushDecode),
  .flushExec      (flushExec),
  .exOpB          (exOpB),
  .memStoreData   (memStoreData),
  .wbWe           (wbWe)
);

// File: tb/tb_pipe_hazard_unit.sv
module tb_pipe_hazard_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TAG_A = 32'hA000_0000;
  localparam logic [31:0] TAG_B = 32'hB000_0000;
  localparam logic [31:0] TAG_E = 32'hE000_0000;
  localparam logic [31:0] TAG_L = 32'hC000_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  inRs1, inRs2, inRd;
  logic        inWe, inLoad, memBranchTaken;
  logic [31:0] rfDataA, rfDataB, exResult, memLoadData;
  logic        stallFetch, stallDecode, flushDecode, flushExec;
  logic [1:0]  fwdSelA, fwdSelB;
  logic [31:0] exOpA, exOpB, memStoreData;
  logic        wbWe;
  logic [4:0]  wbRd;
  logic [31:0] wbValue;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pipe_hazard_unit dut (
    .clk(clk), .rstN(rstN), .inRs1(inRs1), .inRs2(inRs2), .inRd(inRd),
    .inWe(inWe), .inLoad(inLoad), .memBranchTaken(memBranchTaken),
    .rfDataA(rfDataA), .rfDataB(rfDataB), .exResult(exResult),
    .memLoadData(memLoadData), .stallFetch(stallFetch),
    .stallDecode(stallDecode), .flushDecode(flushDecode),
    .flushExec(flushExec), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .exOpA(exOpA), .exOpB(exOpB), .memStoreData(memStoreData),
    .wbWe(wbWe), .wbRd(wbRd), .wbValue(wbValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // apply one cycle of inputs after the falling edge, then let logic settle
  task automatic drive(input logic [4:0] r1, input logic [4:0] r2, input logic [4:0] rd,
                       input logic we, input logic ld, input logic br);
    @(negedge clk);
    inRs1 = r1; inRs2 = r2; inRd = rd; inWe = we; inLoad = ld;
    memBranchTaken = br;
    rfDataA     = TAG_A | 32'(cyc);
    rfDataB     = TAG_B | 32'(cyc);
    exResult    = TAG_E | 32'(cyc);
    memLoadData = TAG_L | 32'(cyc);
    #1;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    rstN = 1'b0;
    inRs1 = 0; inRs2 = 0; inRd = 0; inWe = 0; inLoad = 0; memBranchTaken = 0;
    rfDataA = 0; rfDataB = 0; exResult = 0; memLoadData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R11: reset state
    chk("R11 strobes", {28'd0, stallFetch, stallDecode, flushDecode, flushExec}, 32'd0);
    chk("R11 wbWe", {31'd0, wbWe}, 32'd0);
    chk("R11 store", memStoreData, 32'd0);
    rstN = 1'b1;

    // R4 R5 R7 R10: distance and register sweep, each operand
    for (int op = 0; op < 2; op++) begin
      for (int d = 1; d <= 3; d++) begin
        for (int tgt = 0; tgt < 32; tgt++) begin
          logic [1:0]  expSel;
          logic [31:0] expVal;
          nops(4);
          drive(0, 0, 5'(tgt), 1, 0, 0);
          p = cyc;
          for (int s = 1; s <= d + 3; s++) begin
            if (s == d) begin
              if (op == 0) drive(5'(tgt), 0, 0, 0, 0, 0);
              else         drive(0, 5'(tgt), 0, 0, 0, 0);
            end else begin
              drive(0, 0, 0, 0, 0, 0);
            end
            if (tgt == 0) begin
              expSel = 2'd0; expVal = 32'd0;
            end else if (d == 1) begin
              expSel = 2'd1; expVal = TAG_E | 32'(p + 2);
            end else if (d == 2) begin
              expSel = 2'd2; expVal = TAG_E | 32'(p + 2);
            end else begin
              expSel = 2'd0;
              expVal = ((op == 0) ? TAG_A : TAG_B) | 32'(p + d + 2);
            end
            if (s == d + 2) begin
              if (op == 0) begin
                chk("R4 R5 R7 selA", {30'd0, fwdSelA}, {30'd0, expSel});
                chk("R4 R5 R7 opA", exOpA, expVal);
                chk("R7 other operand x0", exOpB, 32'd0);
              end else begin
                chk("R4 R5 R7 selB", {30'd0, fwdSelB}, {30'd0, expSel});
                chk("R4 R5 R7 opB", exOpB, expVal);
                chk("R7 other operand x0", exOpA, 32'd0);
              end
              chk("R7 no stall", {31'd0, stallDecode}, 32'd0);
            end
            if (s == d + 3 && op == 1)
              chk("R10 store data", memStoreData, expVal);
          end
        end
      end
    end

    // R6: memory stage beats writeback on the same register
    nops(4);
    drive(0, 0, 9, 1, 0, 0); p = cyc;
    drive(0, 0, 9, 1, 0, 0);
    drive(9, 9, 0, 0, 0, 0);
    nops(1);
    nops(1);
    chk("R6 selA", {30'd0, fwdSelA}, 32'd1);
    chk("R6 selB", {30'd0, fwdSelB}, 32'd1);
    chk("R6 opA", exOpA, TAG_E | 32'(p + 3));
    chk("R6 opB", exOpB, TAG_E | 32'(p + 3));

    // R2 R3 R8: load followed at once by a reader, each operand
    for (int op = 0; op < 2; op++) begin
      nops(4);
      drive(0, 0, 6, 1, 1, 0); p = cyc;
      if (op == 0) drive(6, 0, 0, 0, 0, 0); else drive(0, 6, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      chk("R2 stallDecode", {31'd0, stallDecode}, 32'd1);
      chk("R2 stallFetch", {31'd0, stallFetch}, 32'd1);
      chk("R2 no flush", {31'd0, flushDecode}, 32'd0);
      drive(0, 0, 0, 0, 0, 0);
      chk("R3 single stall", {31'd0, stallDecode}, 32'd0);
      drive(0, 0, 0, 0, 0, 0);
      if (op == 0) begin
        chk("R3 selA wb", {30'd0, fwdSelA}, 32'd2);
        chk("R3 opA load", exOpA, TAG_L | 32'(p + 3));
      end else begin
        chk("R3 selB wb", {30'd0, fwdSelB}, 32'd2);
        chk("R3 opB load", exOpB, TAG_L | 32'(p + 3));
      end
      chk("R3 load wb", {26'd0, wbWe, wbRd}, {26'd0, 1'b1, 5'd6});
      chk("R3 load value", wbValue, TAG_L | 32'(p + 3));
      drive(0, 0, 0, 0, 0, 0);
      chk("R8 stall bubble no write", {31'd0, wbWe}, 32'd0);
    end

    // R7: load into x0 does not stall its reader
    nops(4);
    drive(0, 0, 0, 1, 1, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R7 x0 load no stall", {31'd0, stallDecode}, 32'd0);

    // R3: reader two behind a load needs no stall
    nops(4);
    drive(0, 0, 6, 1, 1, 0); p = cyc;
    drive(0, 0, 0, 0, 0, 0);
    drive(6, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R3 gap no stall", {31'd0, stallDecode}, 32'd0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R3 gap no stall later", {31'd0, stallDecode}, 32'd0);
    chk("R3 gap selA", {30'd0, fwdSelA}, 32'd2);
    chk("R3 gap opA", exOpA, TAG_L | 32'(p + 3));

    // R1 R8: taken branch in memory stage
    nops(4);
    drive(0, 0, 10, 1, 0, 0); p = cyc;
    drive(0, 0, 11, 1, 0, 0);
    drive(0, 0, 12, 1, 0, 0);
    drive(11, 12, 13, 1, 0, 1);
    chk("R1 flushDecode", {31'd0, flushDecode}, 32'd1);
    chk("R1 flushExec", {31'd0, flushExec}, 32'd1);
    drive(0, 0, 0, 0, 0, 0);
    chk("R1 branch writes back", {26'd0, wbWe, wbRd}, {26'd0, 1'b1, 5'd10});
    drive(0, 0, 0, 0, 0, 0);
    chk("R1 squashed exec no write", {31'd0, wbWe}, 32'd0);
    chk("R8 no fwd from bubbles A", {30'd0, fwdSelA}, 32'd0);
    chk("R8 no fwd from bubbles B", {30'd0, fwdSelB}, 32'd0);
    chk("R8 opA from regfile", exOpA, TAG_A | 32'(p + 5));
    drive(0, 0, 0, 0, 0, 0);
    chk("R1 squashed decode no write", {31'd0, wbWe}, 32'd0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R1 target instr writes", {26'd0, wbWe, wbRd}, {26'd0, 1'b1, 5'd13});

    // R9: flush and load-use stall in the same cycle
    nops(4);
    drive(0, 0, 6, 1, 1, 0);
    drive(6, 0, 0, 0, 0, 0);
    drive(0, 0, 14, 1, 0, 1);
    chk("R9 stallDecode low", {31'd0, stallDecode}, 32'd0);
    chk("R9 stallFetch low", {31'd0, stallFetch}, 32'd0);
    chk("R9 flushDecode high", {31'd0, flushDecode}, 32'd1);
    drive(0, 0, 0, 0, 0, 0);
    chk("R9 no stall after", {31'd0, stallDecode}, 32'd0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R9 squashed load no write", {31'd0, wbWe}, 32'd0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R9 fetched instr accepted", {26'd0, wbWe, wbRd}, {26'd0, 1'b1, 5'd14});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule